// File: doc/BRIEF.md
# Programmable Periodic Interval Timer

This block produces a periodic interrupt from a fixed millisecond time base. A prescaler divides the system clock by a parameterised number of cycles per millisecond. It emits a one-cycle millisecond strobe. A period counter counts those strobes up to a software-written reload value. The result is a period of (reload + 1) milliseconds. At every expiry the level interrupt is raised and the next period starts on its own.

Software reaches the timer over a small register bus with two locations. A write to the reload location loads a new period. That write also lowers the interrupt and restarts both the prescaler and the period counter from zero. A read of the count location acknowledges the interrupt by lowering it, and the read always returns zero. Every other access has no effect on the timer.

Top module: `ivl_tick_timer`

## Requirements
- R1: After reset the interrupt is low, the reload value is 0 and read data is zero. With no write, the first interrupt rises exactly CYC_PER_MS clock cycles after reset is released.
- R2: After a reload write of value R that is captured at clock edge E, the interrupt rises at edge E + (R+1)*CYC_PER_MS.
- R3: A reload write lowers the interrupt at the capturing edge and restarts the period from zero, discarding any partly elapsed time.
- R4: A read at COUNT_ADDR (bus_sel=1, bus_rd=1, bus_wr=0) lowers the interrupt at the capturing edge. The next cycle it presents all-zero bus_rdata.
- R5: If a count read and a period expiry share the same edge, the expiry wins and the interrupt is high after that edge.
- R6: Expiries repeat every (R+1)*CYC_PER_MS cycles without software action. An unacknowledged interrupt stays high.
- R7: The millisecond strobe is one cycle wide. It occurs every CYC_PER_MS cycles, counted from reset release or from the last reload write.
- R8: Only bits [RELOAD_W-1:0] of bus_wdata form the reload value. Higher bits have no effect on the period.
- R9: Writes to any address other than RELOAD_ADDR, and reads of any address other than COUNT_ADDR, leave the interrupt and the period timing unchanged. Such reads return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier (has priority over bus_rd) |
| bus_rd | input | 1 | Read qualifier |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read |
| irq_o | output | 1 | Level interrupt |

## Verification
On every cycle the assertions check the following:
- the interrupt priorities: a reload write clears it, an expiry beats an acknowledge, and a bare acknowledge clears it;
- that the interrupt only rises after an expiry;
- that the period counter never passes the reload value;
- that the millisecond strobe is one cycle wide and spaced exactly CYC_PER_MS cycles apart.

Only the bench scenarios show the end-to-end timing seen at the ports. That covers the absolute edge at which the interrupt rises after reset or after a reload write, and the discarding of elapsed time on restart. It also covers masking of high write-data bits, the zero read data, and the lack of effect of accesses to other addresses.

// File: rtl/ivl_tick_pkg.sv
package ivl_tick_pkg;

   // Kind of register access decoded in a cycle
   typedef enum logic [1:0] {
      ACC_IDLE      = 2'd0,
      ACC_RELOAD_WR = 2'd1,
      ACC_COUNT_RD  = 2'd2,
      ACC_UNMAPPED  = 2'd3
   } acc_kind_e;

   // Width of a counter that must hold values 0 .. n-1
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/ivl_reg_port.sv
module ivl_reg_port
   import ivl_tick_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned RELOAD_W    = 16,
   parameter int unsigned RELOAD_ADDR = 'h14,
   parameter int unsigned COUNT_ADDR  = 'h1C
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic [RELOAD_W-1:0] reload_o,
   output logic                restart_o,
   output logic                ack_o
);

   localparam logic [ADDR_W-1:0] RELOAD_LOC = ADDR_W'(RELOAD_ADDR);
   localparam logic [ADDR_W-1:0] COUNT_LOC  = ADDR_W'(COUNT_ADDR);
   localparam logic [DATA_W-1:0] READ_VALUE = '0;

   acc_kind_e acc;

   always_comb begin
      acc = ACC_IDLE;
      if (bus_sel) begin
         if (bus_wr)
            acc = (bus_addr == RELOAD_LOC) ? ACC_RELOAD_WR : ACC_UNMAPPED;
         else if (bus_rd)
            acc = (bus_addr == COUNT_LOC) ? ACC_COUNT_RD : ACC_UNMAPPED;
      end
   end

   assign restart_o = (acc == ACC_RELOAD_WR);
   assign ack_o     = (acc == ACC_COUNT_RD);

   always_ff @(posedge clk) begin
      if (!rst_n)
         reload_o <= '0;
      else if (restart_o)
         reload_o <= bus_wdata[RELOAD_W-1:0];
   end

   // Every read, mapped or not, returns zero one cycle later
   always_ff @(posedge clk) begin
      if (!rst_n)
         bus_rdata <= '0;
      else if (bus_sel && bus_rd && !bus_wr)
         bus_rdata <= READ_VALUE;
   end

   generate
      if (RELOAD_W < DATA_W) begin : g_hi_bits
         logic unused_hi;
         assign unused_hi = ^bus_wdata[DATA_W-1:RELOAD_W];
      end
   endgenerate

endmodule

// File: rtl/ivl_ms_prescaler.sv
module ivl_ms_prescaler
   import ivl_tick_pkg::*;
#(
   parameter int unsigned CYC_PER_MS = 250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart_i,
   output logic tick_o
);

   generate
      if (CYC_PER_MS == 1) begin : g_bypass
         // Every cycle is a full millisecond
         logic unused_in;
         assign unused_in = ^{clk, rst_n, restart_i};
         assign tick_o    = 1'b1;
      end else begin : g_count
         localparam int unsigned PS_W = cnt_width(CYC_PER_MS);
         localparam logic [PS_W-1:0] LAST = PS_W'(CYC_PER_MS - 1);

         logic [PS_W-1:0] cnt;

         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt <= '0;
            else if (restart_i)
               cnt <= '0;
            else if (cnt == LAST)
               cnt <= '0;
            else
               cnt <= cnt + 1'b1;
         end

         assign tick_o = (cnt == LAST);
      end
   endgenerate

endmodule

// File: rtl/ivl_period_counter.sv
module ivl_period_counter #(
   parameter int unsigned RELOAD_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                restart_i,
   input  logic                ms_tick_i,
   input  logic [RELOAD_W-1:0] reload_i,
   output logic                expire_o,
   output logic [RELOAD_W-1:0] count_o
);

   logic at_end;

   assign at_end   = (count_o == reload_i);
   // A restart in the same cycle discards the strobe
   assign expire_o = ms_tick_i && !restart_i && at_end;

   always_ff @(posedge clk) begin
      if (!rst_n)
         count_o <= '0;
      else if (restart_i)
         count_o <= '0;
      else if (ms_tick_i)
         count_o <= at_end ? '0 : count_o + 1'b1;
   end

endmodule

// File: rtl/ivl_irq_latch.sv
module ivl_irq_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic irq_o
);

   // Set beats clear
   always_ff @(posedge clk) begin
      if (!rst_n)
         irq_o <= 1'b0;
      else if (set_i)
         irq_o <= 1'b1;
      else if (clr_i)
         irq_o <= 1'b0;
   end

endmodule

// File: rtl/ivl_tick_timer.sv
module ivl_tick_timer
   import ivl_tick_pkg::*;
#(
   parameter int unsigned CYC_PER_MS  = 250000,
   parameter int unsigned RELOAD_W    = 16,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned RELOAD_ADDR = 'h14,
   parameter int unsigned COUNT_ADDR  = 'h1C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o
);

   // Elaboration-time parameter checks
   generate
      if (CYC_PER_MS < 1) begin : g_bad_cyc
         $error("CYC_PER_MS must be at least 1");
      end
      if (RELOAD_W < 1 || RELOAD_W > DATA_W) begin : g_bad_rw
         $error("RELOAD_W must lie in 1..DATA_W");
      end
      if (RELOAD_ADDR == COUNT_ADDR) begin : g_bad_map
         $error("RELOAD_ADDR and COUNT_ADDR must differ");
      end
      if (ADDR_W < 32 && (RELOAD_ADDR >= (1 << ADDR_W) || COUNT_ADDR >= (1 << ADDR_W))) begin : g_bad_addr
         $error("register addresses must fit in ADDR_W");
      end
   endgenerate

   logic [RELOAD_W-1:0] reload_w;
   logic [RELOAD_W-1:0] per_count_w;
   logic                restart_w;
   logic                ack_w;
   logic                ms_tick_w;
   logic                expire_w;

   ivl_reg_port #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .RELOAD_W   (RELOAD_W),
      .RELOAD_ADDR(RELOAD_ADDR),
      .COUNT_ADDR (COUNT_ADDR)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .reload_o  (reload_w),
      .restart_o (restart_w),
      .ack_o     (ack_w)
   );

   ivl_ms_prescaler #(
      .CYC_PER_MS(CYC_PER_MS)
   ) presc_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (restart_w),
      .tick_o    (ms_tick_w)
   );

   ivl_period_counter #(
      .RELOAD_W(RELOAD_W)
   ) period_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (restart_w),
      .ms_tick_i (ms_tick_w),
      .reload_i  (reload_w),
      .expire_o  (expire_w),
      .count_o   (per_count_w)
   );

   // expire_w is already gated by restart, so a write beats an expiry
   ivl_irq_latch irq_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (expire_w),
      .clr_i (restart_w | ack_w),
      .irq_o (irq_o)
   );

endmodule

// File: rtl/ivl_tick_timer_chk.sv
module ivl_tick_timer_chk #(
   parameter int unsigned CYC_PER_MS = 250000,
   parameter int unsigned RELOAD_W   = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                irq_o,
   input logic                restart,
   input logic                ack,
   input logic                ms_tick,
   input logic                expire,
   input logic [RELOAD_W-1:0] per_count,
   input logic [RELOAD_W-1:0] reload
);

   // Cycles since reset release, last restart or last strobe
   int unsigned gap;

   always_ff @(posedge clk) begin
      if (!rst_n || restart || ms_tick)
         gap <= 0;
      else
         gap <= gap + 1;
   end

   a_r3_write_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !irq_o);

   a_r3_write_zeroes_count: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (per_count == '0));

   a_r4_ack_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !expire) |=> !irq_o);

   a_r5_expiry_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> irq_o);

   a_r6_rise_from_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(expire));

   a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      per_count <= reload);

   a_r7_strobe_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      ms_tick |-> (gap == CYC_PER_MS - 1));

   a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      ((CYC_PER_MS > 1) && ms_tick) |=> !ms_tick);

endmodule

bind ivl_tick_timer ivl_tick_timer_chk #(
   .CYC_PER_MS(CYC_PER_MS),
   .RELOAD_W  (RELOAD_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_o     (irq_o),
   .restart   (restart_w),
   .ack       (ack_w),
   .ms_tick   (ms_tick_w),
   .expire    (expire_w),
   .per_count (per_count_w),
   .reload    (reload_w)
);

// File: tb/ivl_tick_timer_tb_top.sv
`timescale 1ns/1ps
module ivl_tick_timer_tb_top;

   localparam int unsigned CYC     = 8;
   localparam int unsigned RW      = 4;
   localparam int unsigned AW      = 8;
   localparam int unsigned DW      = 32;
   localparam int unsigned RLD_A   = 'h14;
   localparam int unsigned CNT_A   = 'h1C;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          irq_o;

   int unsigned cyc = 0;
   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ivl_tick_timer #(
      .CYC_PER_MS (CYC),
      .RELOAD_W   (RW),
      .ADDR_W     (AW),
      .DATA_W     (DW),
      .RELOAD_ADDR(RLD_A),
      .COUNT_ADDR (CNT_A)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o)
   );

   function automatic int exp_period(input int r);
      return (r + 1) * CYC;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_write(input int unsigned a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic do_read(input int unsigned a, output logic [DW-1:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = AW'(a);
      @(negedge clk);
      bus_sel = 1'b0; bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic wait_rise(output int unsigned t);
      int n = 0;
      while (!irq_o && n < 2000) begin
         @(negedge clk);
         n++;
      end
      t = cyc;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      finish_run();
   end

   initial begin
      int unsigned t0, t1, t2, trel;
      logic [DW-1:0] rd;
      void'($urandom(32'd1357));

      // R1: reset state and first expiry with reload 0
      idle(4);
      check(irq_o == 1'b0, "R1", "irq during reset", irq_o, 0);
      check(bus_rdata == '0, "R1", "rdata during reset", bus_rdata, 0);
      @(negedge clk);
      trel = cyc; rst_n = 1'b1;
      wait_rise(t1);
      check(t1 - trel == CYC, "R1", "first rise after reset", t1 - trel, CYC);

      // R6: stays high without acknowledge
      idle(3);
      check(irq_o == 1'b1, "R6", "irq held unacknowledged", irq_o, 1);

      // R4: acknowledge read
      do_read(CNT_A, rd);
      check(irq_o == 1'b0, "R4", "irq after count read", irq_o, 0);
      check(rd == '0, "R4", "count read data", rd, 0);
      // R7: strobe cadence with reload 0
      wait_rise(t2);
      check(t2 - t1 == CYC, "R7", "spacing at reload 0", t2 - t1, CYC);

      // R3 and R8: write with high garbage bits, irq cleared at once
      do_write(RLD_A, 32'hABCD_0003);
      t0 = cyc;
      check(irq_o == 1'b0, "R3", "irq after reload write", irq_o, 0);
      wait_rise(t1);
      check(t1 - t0 == exp_period(3), "R8", "period with high bits set", t1 - t0, exp_period(3));

      // R3: restart mid-period discards elapsed time
      do_write(RLD_A, 32'd5);
      idle(20);
      do_write(RLD_A, 32'd5);
      t0 = cyc;
      wait_rise(t1);
      check(t1 - t0 == exp_period(5), "R3", "restart mid period", t1 - t0, exp_period(5));
      do_write(RLD_A, 32'd1);
      t0 = cyc;
      check(irq_o == 1'b0, "R3", "write clears raised irq", irq_o, 0);
      wait_rise(t1);
      check(t1 - t0 == exp_period(1), "R2", "period reload 1", t1 - t0, exp_period(1));

      // R5: acknowledge on the expiry edge
      do_write(RLD_A, 32'd2);
      t0 = cyc;
      while (cyc < t0 + exp_period(2) - 1) @(negedge clk);
      bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = AW'(CNT_A);
      @(negedge clk);
      bus_sel = 1'b0; bus_rd = 1'b0;
      check(irq_o == 1'b1, "R5", "expiry beats ack", irq_o, 1);
      do_read(CNT_A, rd);
      check(irq_o == 1'b0, "R5", "later ack clears", irq_o, 0);

      // R9: other addresses have no effect
      do_write(RLD_A, 32'd3);
      t0 = cyc;
      idle(6);
      do_write('h40, 32'd0);
      do_read('h44, rd);
      check(rd == '0, "R9", "unmapped read data", rd, 0);
      wait_rise(t1);
      check(t1 - t0 == exp_period(3), "R9", "timing after unmapped access", t1 - t0, exp_period(3));
      do_write('h40, 32'hFFFF_FFFF);
      check(irq_o == 1'b1, "R9", "irq after unmapped write", irq_o, 1);
      do_write(CNT_A, 32'd0);
      check(irq_o == 1'b1, "R9", "irq after write to count", irq_o, 1);
      do_read(RLD_A, rd);
      check(irq_o == 1'b1, "R9", "irq after read of reload", irq_o, 1);
      check(rd == '0, "R9", "reload location read data", rd, 0);

      // R2 and R6: random reloads, random acknowledge point
      for (int it = 0; it < 10; it++) begin
         int r;
         int p;
         int k;
         logic [DW-1:0] w;
         r = int'($urandom_range(0, (1 << RW) - 1));
         p = exp_period(r);
         w = $urandom;
         w[RW-1:0] = RW'(r);
         do_write(RLD_A, w);
         t0 = cyc;
         wait_rise(t1);
         check(t1 - t0 == p, "R2", "random period", t1 - t0, p);
         k = int'($urandom_range(0, p - 4));
         idle(k);
         do_read(CNT_A, rd);
         check(irq_o == 1'b0, "R4", "random ack", irq_o, 0);
         wait_rise(t2);
         check(t2 - t1 == p, "R6", "auto repeat", t2 - t1, p);
      end

      finish_run();
   end

endmodule